// File: doc/BRIEF.md
# Vectored interrupt request controller

This block gathers interrupt events from external pins and from on-chip peripherals into one request latch per vector. It reports the highest-priority serviceable vector to the processor as an index with a valid flag. A request is serviceable when its latch is set, its enable bit is set and the global disable flag is clear. Vector 0 is a software break. It ignores both the enable bits and the disable flag, so it cannot be masked.

Several peripheral vectors are shared. For each of them, one bit of a source-select register picks either the peripheral level or an alternate source. The lowest-numbered external lines can take their level from either of two pins, and one switch bit chooses the pin for all of them together. Every external line passes through a synchroniser and then an edge detector, and a per-line edge-select bit sets which edge is active. The edge detector sits after the source and pin multiplexers. Because of that, reprogramming a polarity, a source or the pin switch can latch a request by itself whenever the selected level has changed.

Software reads and writes the configuration through a small register port. A write to the request register can only clear latches, never set them. When the processor accepts the presented vector, the block sets the disable flag and clears that vector's latch on the same clock edge. A separate one-bit port lets the processor write the disable flag, for example to re-enable interrupts at the end of a handler.

Top module: `irq_vec_ctrl`

## Requirements
- R1: `irq_valid` is high for a maskable vector only when its request latch is 1, its enable bit is 1 and `dis_flag` is 0. After reset `dis_flag` is 1, all enable bits are 0 and `irq_valid` is 0. Writing `dis_wdata` with `dis_wr` high loads `dis_flag` on the next edge.
- R2: Register address 0 reads the request latches, with bit n holding vector n. Writing address 0 clears every latch whose data bit is 0, and a data bit of 1 leaves its latch unchanged. A request latch rises only on a detected event.
- R3: The break input latches request 0. That request is presented as `irq_vec` = 0 whatever the enable bits (address 1, bit n enables vector n, bit 0 reads 0) and whatever `dis_flag` holds.
- R4: Among all serviceable requests, the one with the lowest vector index is presented on `irq_vec`.
- R5: `irq_ack` while `irq_valid` is high sets `dis_flag` and clears the latch of the presented vector on the same edge. Other latches are kept.
- R6: Vectors 8 to 15 are shared. Bit s of address 2 selects `alt_src[s]` (1) or the peripheral level (0) for vector 8+s. Peripheral level p feeds vector 7+p. Peripheral and alternate sources request on a rising edge, and the source that is not selected has no effect.
- R7: External line e feeds vector 1+e. For lines 0 to 2, address 4 bit 0 selects `ext_pin_b[e]` (1) or `ext_pin_a[e]` (0). The pin that is not selected has no effect.
- R8: When a write to address 3, address 2 or the pin switch changes the selected level as seen by the edge detector into its active state, the affected request latch is set as if an edge had arrived.
- R9: Address 3 bit e selects the active edge of external line e: 1 for rising, 0 for falling. It resets to all ones. The opposite edge does not request. A pin edge driven before clock edge k is latched at edge k+2 and can be read after it.
- R10: When a request event and a software clear of the same latch arrive in the same cycle, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_a | input | NUM_EXT (6) | Primary external interrupt pins, asynchronous |
| ext_pin_b | input | NUM_ALTPIN (3) | Alternate pins for external lines 0..2 |
| periph_lvl | input | NUM_MASK-NUM_EXT (9) | Peripheral request levels, synchronous |
| alt_src | input | NUM_SHARED (8) | Alternate sources for shared vectors |
| brk_req | input | 1 | Software break event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W (16) | Register write data |
| reg_rdata | output | DATA_W (16) | Register read data, combinational |
| dis_wr | input | 1 | Disable flag write strobe |
| dis_wdata | input | 1 | Disable flag write value |
| dis_flag | output | 1 | Global interrupt disable flag |
| irq_valid | output | 1 | A serviceable request is presented |
| irq_vec | output | 4 | Presented vector index |
| irq_ack | input | 1 | Processor accepts the presented vector |

## Verification
A corrupted request latch shows on the request register the cycle after it happens. Once the vector is enabled and the disable flag is clear, it also shows as a wrong `irq_valid` or `irq_vec` in that same cycle, because the priority path is combinational from the latches. A fault in the edge detector's previous-level state, or in the synchroniser depth, shows as a latency off by one cycle from the two-edge pin path, as a missed or doubled request after a reconfiguration write, or as a request on the wrong polarity. A wrong disable flag or a wrong clear on acceptance appears one cycle after `irq_ack`, on `dis_flag` and on the next presented vector.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_REQ   = 3'd0,
      RA_ENA   = 3'd1,
      RA_SRC   = 3'd2,
      RA_EDGE  = 3'd3,
      RA_PINSW = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
   parameter int N = 15
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] act_hi,
   input  logic [N-1:0] clr,
   output logic [N-1:0] evt,
   output logic [N-1:0] req
);
   logic [N-1:0] adj;
   logic [N-1:0] prev_q;
   logic [N-1:0] req_q;

   // polarity-adjusted level: active state reads as 1
   assign adj = ~(lvl ^ act_hi);
   assign evt = adj & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         req_q  <= '0;
      end else begin
         prev_q <= adj;
         // an event outranks any clear in the same cycle
         req_q  <= evt | (req_q & ~clr);
      end
   end

   assign req = req_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N     = 16,
   parameter int IDX_W = 4
)(
   input  logic [N-1:0]     pend,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);
   if ((1 << IDX_W) < N) begin : g_bad_width
      $error("irq_prio_enc: IDX_W too narrow for N");
   end

   always_comb begin
      valid = |pend;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_vec_pkg::*;
#(
   parameter int NUM_MASK    = 15,
   parameter int NUM_EXT     = 6,
   parameter int NUM_ALTPIN  = 3,
   parameter int NUM_SHARED  = 8,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_EXT-1:0]               ext_pin_a,
   input  logic [NUM_ALTPIN-1:0]            ext_pin_b,
   input  logic [NUM_MASK-NUM_EXT-1:0]      periph_lvl,
   input  logic [NUM_SHARED-1:0]            alt_src,
   input  logic                             brk_req,
   input  logic                             reg_wr,
   input  logic [REG_AW-1:0]                reg_addr,
   input  logic [DATA_W-1:0]                reg_wdata,
   output logic [DATA_W-1:0]                reg_rdata,
   input  logic                             dis_wr,
   input  logic                             dis_wdata,
   output logic                             dis_flag,
   output logic                             irq_valid,
   output logic [$clog2(NUM_MASK+1)-1:0]    irq_vec,
   input  logic                             irq_ack
);
   localparam int NUM_VEC    = NUM_MASK + 1;
   localparam int IDX_W      = $clog2(NUM_VEC);
   localparam int NUM_PERIPH = NUM_MASK - NUM_EXT;
   localparam int SH_BASE    = NUM_VEC - NUM_SHARED;
   localparam int PIN_W      = NUM_EXT + NUM_ALTPIN;

   if (NUM_EXT + NUM_SHARED > NUM_MASK) begin : g_bad_share
      $error("irq_vec_ctrl: shared vectors overlap external lines");
   end
   if (NUM_ALTPIN > NUM_EXT) begin : g_bad_alt
      $error("irq_vec_ctrl: more alternate pins than external lines");
   end
   if (DATA_W < NUM_VEC) begin : g_bad_data
      $error("irq_vec_ctrl: DATA_W narrower than vector count");
   end

   // configuration and flag state
   logic [NUM_MASK-1:0]   ena_q;
   logic [NUM_SHARED-1:0] srcsel_q;
   logic [NUM_EXT-1:0]    edge_q;
   logic                  pinsw_q;
   logic                  dis_q;
   logic                  brk_q;

   // synchronised pins: a set in the low slice, b set above it
   logic [PIN_W-1:0] pin_s;

   irq_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_pin_b, ext_pin_a}),
      .q     (pin_s)
   );

   // selected level and active polarity per maskable vector (index = vector-1)
   logic [NUM_MASK-1:0] lvl_m;
   logic [NUM_MASK-1:0] act_hi_m;

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      if (e < NUM_ALTPIN) begin : g_sw
         assign lvl_m[e] = pinsw_q ? pin_s[NUM_EXT+e] : pin_s[e];
      end else begin : g_fix
         assign lvl_m[e] = pin_s[e];
      end
      assign act_hi_m[e] = edge_q[e];
   end

   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
      localparam int M = NUM_EXT + p;
      localparam int V = M + 1;
      if (V >= SH_BASE) begin : g_shared
         assign lvl_m[M] = srcsel_q[V-SH_BASE] ? alt_src[V-SH_BASE] : periph_lvl[p];
      end else begin : g_plain
         assign lvl_m[M] = periph_lvl[p];
      end
      assign act_hi_m[M] = 1'b1;
   end

   // clear sources: software write-zero and acceptance
   logic                wr_req;
   logic                ack_fire;
   logic [NUM_VEC-1:0]  ack_onehot;
   logic [NUM_VEC-1:0]  clr_all;
   logic [NUM_MASK-1:0] evt_m;
   logic [NUM_MASK-1:0] req_m;
   logic [NUM_VEC-1:0]  req_all;
   logic [NUM_VEC-1:0]  pend;

   assign wr_req   = reg_wr && (reg_addr == RA_REQ);
   assign ack_fire = irq_ack && irq_valid;

   always_comb begin
      for (int i = 0; i < NUM_VEC; i++) begin
         ack_onehot[i] = ack_fire && (irq_vec == IDX_W'(i));
      end
      clr_all = ack_onehot | (wr_req ? ~reg_wdata[NUM_VEC-1:0] : '0);
   end

   irq_req_bank #(.N(NUM_MASK)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_m),
      .act_hi (act_hi_m),
      .clr    (clr_all[NUM_VEC-1:1]),
      .evt    (evt_m),
      .req    (req_m)
   );

   assign req_all = {req_m, brk_q};
   assign pend    = {req_m & ena_q & {NUM_MASK{~dis_q}}, brk_q};

   irq_prio_enc #(.N(NUM_VEC), .IDX_W(IDX_W)) u_prio (
      .pend  (pend),
      .valid (irq_valid),
      .idx   (irq_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q    <= '0;
         srcsel_q <= '0;
         edge_q   <= '1;
         pinsw_q  <= 1'b0;
         dis_q    <= 1'b1;
         brk_q    <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               RA_ENA:   ena_q    <= reg_wdata[NUM_VEC-1:1];
               RA_SRC:   srcsel_q <= reg_wdata[NUM_SHARED-1:0];
               RA_EDGE:  edge_q   <= reg_wdata[NUM_EXT-1:0];
               RA_PINSW: pinsw_q  <= reg_wdata[0];
               default: ;
            endcase
         end
         if (ack_fire)    dis_q <= 1'b1;
         else if (dis_wr) dis_q <= dis_wdata;
         brk_q <= brk_req | (brk_q & ~clr_all[0]);
      end
   end

   assign dis_flag = dis_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_REQ:   reg_rdata[NUM_VEC-1:0]    = req_all;
         RA_ENA:   reg_rdata[NUM_VEC-1:1]    = ena_q;
         RA_SRC:   reg_rdata[NUM_SHARED-1:0] = srcsel_q;
         RA_EDGE:  reg_rdata[NUM_EXT-1:0]    = edge_q;
         RA_PINSW: reg_rdata[0]              = pinsw_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int NUM_VEC = 16,
   parameter int IDX_W   = 4
)(
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] req,
   input logic [NUM_VEC-1:0] ena,
   input logic [NUM_VEC-1:0] pend,
   input logic [NUM_VEC-1:0] evt,
   input logic               dis_flag,
   input logic               irq_valid,
   input logic [IDX_W-1:0]   irq_vec,
   input logic               irq_ack
);
   localparam int VW = NUM_VEC;

   // R1: a maskable vector is shown only when latched, enabled and not disabled
   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_vec != '0) |-> (!dis_flag && ena[irq_vec] && req[irq_vec]));

   // R2: latches rise only after a detected event
   assert_req_by_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((req & ~$past(req) & ~$past(evt)) == '0));

   // R3: a pending break is always the presented vector
   assert_brk_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> (irq_valid && irq_vec == '0));

   // R4: nothing serviceable sits below the presented index
   assert_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (pend[irq_vec] && ((pend & ((VW'(1) << irq_vec) - VW'(1))) == '0)));

   // R5: acceptance sets the disable flag
   assert_ack_dis_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid) |=> dis_flag);

   // R5: acceptance clears the accepted latch unless a new event arrived
   assert_ack_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid) |=> (!req[$past(irq_vec)] || $past(evt[irq_vec])));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_VEC(NUM_MASK + 1), .IDX_W($clog2(NUM_MASK + 1))) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req_all),
   .ena       ({ena_q, 1'b0}),
   .pend      (pend),
   .evt       ({evt_m, brk_req}),
   .dis_flag  (dis_flag),
   .irq_valid (irq_valid),
   .irq_vec   (irq_vec),
   .irq_ack   (irq_ack)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
   localparam logic [2:0] A_REQ = 3'd0, A_ENA = 3'd1, A_SRC = 3'd2, A_EDGE = 3'd3, A_PSW = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  ext_pin_a = '0;
   logic [2:0]  ext_pin_b = '0;
   logic [8:0]  periph_lvl = '0;
   logic [7:0]  alt_src = '0;
   logic        brk_req = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        dis_wr = 1'b0;
   logic        dis_wdata = 1'b0;
   logic        dis_flag;
   logic        irq_valid;
   logic [3:0]  irq_vec;
   logic        irq_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_vec_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ext_pin_a(ext_pin_a), .ext_pin_b(ext_pin_b),
      .periph_lvl(periph_lvl), .alt_src(alt_src), .brk_req(brk_req),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dis_wr(dis_wr), .dis_wdata(dis_wdata), .dis_flag(dis_flag),
      .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ack(irq_ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic set_dis(input logic v);
      @(negedge clk); dis_wr = 1'b1; dis_wdata = v;
      @(negedge clk); dis_wr = 1'b0;
   endtask

   task automatic pulse_per(input int p);
      @(negedge clk); periph_lvl[p] = 1'b1;
      @(negedge clk); periph_lvl[p] = 1'b0;
   endtask

   task automatic pulse_alt(input int s);
      @(negedge clk); alt_src[s] = 1'b1;
      @(negedge clk); alt_src[s] = 1'b0;
   endtask

   task automatic pulse_brk();
      @(negedge clk); brk_req = 1'b1;
      @(negedge clk); brk_req = 1'b0;
   endtask

   task automatic pulse_pin(input bit use_b, input int e);
      @(negedge clk);
      if (use_b) ext_pin_b[e] = 1'b1; else ext_pin_a[e] = 1'b1;
      cyc(5);
      if (use_b) ext_pin_b[e] = 1'b0; else ext_pin_a[e] = 1'b0;
      cyc(5);
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic cleanup();
      set_dis(1'b1);
      wr(A_ENA, 16'h0000);
      wr(A_SRC, 16'h0000);
      wr(A_PSW, 16'h0000);
      wr(A_EDGE, 16'h003F);
      cyc(4);
      wr(A_REQ, 16'h0000);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 reset irq_valid", irq_valid, 0);
      chk("R1 reset dis_flag", dis_flag, 1);
      rd(A_REQ, d);  chk("R2 reset request register", d, 16'h0000);
      rd(A_ENA, d);  chk("R1 reset enables", d, 16'h0000);
      rd(A_EDGE, d); chk("R9 reset edge selects", d, 16'h003F);
   endtask

   task automatic t_gate();
      logic [15:0] d;
      pulse_per(0);
      rd(A_REQ, d); chk("R1 latched while not enabled", d, 16'h0080);
      chk("R1 no valid when not enabled", irq_valid, 0);
      wr(A_ENA, 16'h0080);
      chk("R1 no valid while disabled", irq_valid, 0);
      set_dis(1'b0);
      chk("R1 dis_flag written 0", dis_flag, 0);
      chk("R1 valid when all gates open", irq_valid, 1);
      chk("R1 vector 7 presented", irq_vec, 7);
      wr(A_ENA, 16'h0000);
      chk("R1 valid drops on disable bit", irq_valid, 0);
      cleanup();
   endtask

   task automatic t_swclr();
      logic [15:0] d;
      wr(A_REQ, 16'hFFFF);
      rd(A_REQ, d); chk("R2 write of ones sets nothing", d, 16'h0000);
      pulse_per(0); pulse_per(3);
      rd(A_REQ, d); chk("R2 two latches set", d, 16'h0480);
      wr(A_REQ, 16'hFF7F);
      rd(A_REQ, d); chk("R2 only zero bit cleared", d, 16'h0400);
   endtask

   task automatic t_race();
      logic [15:0] d;
      @(negedge clk);
      periph_lvl[3] = 1'b1; reg_wr = 1'b1; reg_addr = A_REQ; reg_wdata = 16'hFBFF;
      @(negedge clk);
      periph_lvl[3] = 1'b0; reg_wr = 1'b0;
      rd(A_REQ, d); chk("R10 event beats clear", d, 16'h0400);
      wr(A_REQ, 16'hFBFF);
      rd(A_REQ, d); chk("R10 plain clear works", d, 16'h0000);
      cleanup();
   endtask

   task automatic t_brk();
      logic [15:0] d;
      pulse_brk();
      chk("R3 break valid while masked", irq_valid, 1);
      chk("R3 break index", irq_vec, 0);
      ack();
      rd(A_REQ, d); chk("R3 break latch cleared by accept", d, 16'h0000);
      chk("R3 nothing after break", irq_valid, 0);
      cleanup();
   endtask

   task automatic t_prio();
      wr(A_ENA, 16'hFFFE);
      set_dis(1'b0);
      pulse_per(8); pulse_per(5); pulse_per(3);
      chk("R4 lowest of 10/12/15", irq_vec, 10);
      wr(A_REQ, 16'hFBFF);
      chk("R4 next lowest", irq_vec, 12);
      pulse_brk();
      chk("R4 break above maskable", irq_vec, 0);
      wr(A_REQ, 16'hFFFE);
      chk("R4 back to 12", irq_vec, 12);
      cleanup();
   endtask

   task automatic t_ack();
      logic [15:0] d;
      wr(A_ENA, 16'h0280);
      set_dis(1'b0);
      pulse_per(0); pulse_per(2);
      chk("R5 vector 7 first", irq_vec, 7);
      ack();
      chk("R5 dis_flag set by accept", dis_flag, 1);
      chk("R5 valid off after accept", irq_valid, 0);
      rd(A_REQ, d); chk("R5 only accepted latch cleared", d, 16'h0200);
      set_dis(1'b0);
      chk("R5 vector 9 after re-enable", irq_vec, 9);
      cleanup();
   endtask

   task automatic t_shared();
      logic [15:0] d;
      pulse_alt(1);
      rd(A_REQ, d); chk("R6 unselected alternate ignored", d, 16'h0000);
      pulse_per(2);
      rd(A_REQ, d); chk("R6 peripheral feeds vector 9", d, 16'h0200);
      wr(A_REQ, 16'h0000);
      wr(A_SRC, 16'h0002);
      rd(A_SRC, d); chk("R6 source select readback", d, 16'h0002);
      pulse_per(2);
      rd(A_REQ, d); chk("R6 unselected peripheral ignored", d, 16'h0000);
      pulse_alt(1);
      rd(A_REQ, d); chk("R6 alternate feeds vector 9", d, 16'h0200);
      cleanup();
   endtask

   task automatic t_pinsw();
      logic [15:0] d;
      pulse_pin(1'b1, 1);
      rd(A_REQ, d); chk("R7 pin b ignored when switch 0", d, 16'h0000);
      pulse_pin(1'b0, 1);
      rd(A_REQ, d); chk("R7 pin a feeds vector 2", d, 16'h0004);
      wr(A_REQ, 16'h0000);
      wr(A_PSW, 16'h0001);
      pulse_pin(1'b0, 1);
      rd(A_REQ, d); chk("R7 pin a ignored when switch 1", d, 16'h0000);
      pulse_pin(1'b1, 1);
      rd(A_REQ, d); chk("R7 pin b feeds vector 2", d, 16'h0004);
      cleanup();
   endtask

   task automatic t_spurious();
      logic [15:0] d;
      wr(A_EDGE, 16'h003E);
      cyc(1);
      rd(A_REQ, d); chk("R8 polarity change latches vector 1", d, 16'h0002);
      wr(A_EDGE, 16'h003F);
      wr(A_REQ, 16'h0000);
      @(negedge clk); alt_src[1] = 1'b1;
      cyc(2);
      rd(A_REQ, d); chk("R8 held alternate not yet seen", d, 16'h0000);
      wr(A_SRC, 16'h0002);
      cyc(1);
      rd(A_REQ, d); chk("R8 source change latches vector 9", d, 16'h0200);
      alt_src[1] = 1'b0;
      cleanup();
      @(negedge clk); ext_pin_b[2] = 1'b1;
      cyc(5);
      rd(A_REQ, d); chk("R8 held pin b not yet seen", d, 16'h0000);
      wr(A_PSW, 16'h0001);
      cyc(1);
      rd(A_REQ, d); chk("R8 pin switch latches vector 3", d, 16'h0008);
      ext_pin_b[2] = 1'b0;
      cleanup();
   endtask

   task automatic t_edge();
      logic [15:0] d;
      @(negedge clk); ext_pin_a[0] = 1'b1;
      cyc(1); rd(A_REQ, d); chk("R9 rising latency edge 1", d, 16'h0000);
      cyc(1); rd(A_REQ, d); chk("R9 rising latency edge 2", d, 16'h0000);
      cyc(1); rd(A_REQ, d); chk("R9 rising latched at edge 3", d, 16'h0002);
      ext_pin_a[0] = 1'b0;
      cyc(4);
      wr(A_REQ, 16'h0000);
      wr(A_EDGE, 16'h0037);
      cyc(2);
      wr(A_REQ, 16'h0000);
      @(negedge clk); ext_pin_a[3] = 1'b1;
      cyc(4);
      rd(A_REQ, d); chk("R9 rising ignored in falling mode", d, 16'h0000);
      @(negedge clk); ext_pin_a[3] = 1'b0;
      cyc(2); rd(A_REQ, d); chk("R9 falling not before edge 3", d, 16'h0000);
      cyc(1); rd(A_REQ, d); chk("R9 falling latches vector 4", d, 16'h0010);
      cleanup();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all requirements act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_gate();
      t_swclr();
      t_race();
      t_brk();
      t_prio();
      t_ack();
      t_shared();
      t_pinsw();
      t_spurious();
      t_edge();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule